// File: doc/BRIEF.md
# SPI master interrupt aggregator

This block collects the interrupt sources of an SPI master controller and drives one level-sensitive interrupt line. There are two kinds of source. Three are sticky event flags: transmit underflow, receive overflow and mode fault. Each one is latched from a one-cycle pulse. The other four are live level flags, recomputed every cycle from the FIFO occupancy counts, the FIFO full flags and two programmable thresholds.

Software reaches the block through a small register port. It has a read strobe, a write strobe, a 3-bit word address, and 8-bit write and read data. Read data is combinational and valid in the cycle the read strobe is high. All writes, and the clear caused by a status read, take effect at the next rising clock edge.

Software never writes the interrupt mask directly. It sets mask bits through an enable register and clears them through a disable register. Reading the status register returns the current value and clears the sticky flags.

Top module: `spi_irq_aggr`

## Requirements
- R1: The status word (address 0) has this bit layout: bit 0 receive overflow, bit 1 mode fault, bit 2 transmit below threshold, bit 3 transmit full, bit 4 receive at threshold, bit 5 receive full, bit 6 transmit underflow. Bit 7 reads as zero.
- R2: A one-cycle pulse on an event input sets its sticky bit (0, 1 or 6) at the next edge. The bit stays set until software clears it.
- R3: Status bits 3 and 5 follow `tx_full` and `rx_full` in the same cycle, without latching.
- R4: Bit 4 is high when `rx_level` is greater than or equal to the receive threshold. Bit 2 is high when `tx_level` is strictly less than the transmit threshold. The thresholds are written and read at address 4 (transmit) and address 5 (receive).
- R5: Writing address 1 ORs `reg_wdata[6:0]` into the mask. Writing address 2 clears from the mask the bits that are 1 in `reg_wdata[6:0]`. The mask reads at address 3, and writes to address 3 are ignored.
- R6: Writing address 0 clears each sticky bit whose position holds a 1 in `reg_wdata`, and leaves the other sticky bits unchanged.
- R7: A read of address 0 returns the current status word and clears all sticky bits at the next edge.
- R8: `irq` is high whenever any bit of (mask AND status) is 1.
- R9: After reset, both thresholds are 1 and the mask and all sticky bits are 0.
- R10: An event pulse in the same cycle as a clear-on-read or a write-one-to-clear of its bit leaves the bit set.
- R11: Addresses 1, 2, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high, zero otherwise |
| tx_level | input | 6 | Transmit FIFO occupancy |
| rx_level | input | 6 | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| ev_tx_underflow | input | 1 | Transmit underflow event pulse |
| ev_rx_overflow | input | 1 | Receive overflow event pulse |
| ev_mode_fault | input | 1 | Mode fault event pulse |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties are checked on every cycle. They cover:
- event capture, and the priority of an event over a same-cycle clear;
- the clearing effect of status reads and of write-one-to-clear;
- the mask, which changes only through the enable and disable addresses;
- a silent `irq` whenever the mask is empty.

Some behaviours only the bench scenarios can show. These are the exact threshold boundaries (equal, one below and one above), the readback values of every address, and the agreement of `irq` with an independently modelled mask and status across long random runs.

// File: rtl/spi_irq_aggr.sv
module spi_irq_aggr #(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              tx_full,
  input  logic              rx_full,
  input  logic              ev_tx_underflow,
  input  logic              ev_rx_overflow,
  input  logic              ev_mode_fault,
  output logic              irq
);

  localparam int NB = 7;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TTHR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RTHR = ADDR_W'(5);
  localparam logic [NB-1:0] STICKY = 7'b100_0011;

  logic [NB-1:0]     sticky_q, mask_q, status, events, clr;
  logic [DATA_W-1:0] tx_thr_q, rx_thr_q;
  logic              rx_ne, tx_nf;

  assign rx_ne  = DATA_W'(rx_level) >= rx_thr_q;
  assign tx_nf  = DATA_W'(tx_level) <  tx_thr_q;
  assign status = (sticky_q & STICKY) | {1'b0, rx_full, rx_ne, tx_full, tx_nf, 2'b00};
  assign events = {ev_tx_underflow, 4'b0000, ev_mode_fault, ev_rx_overflow};
  assign clr    = ((reg_rd && reg_addr == A_STAT) ? STICKY : '0)
                | ((reg_wr && reg_addr == A_STAT) ? reg_wdata[NB-1:0] : '0);
  assign irq    = |(mask_q & status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= '0;
      tx_thr_q <= DATA_W'(1);
      rx_thr_q <= DATA_W'(1);
    end else begin
      sticky_q <= ((sticky_q & ~clr) | events) & STICKY;
      if (reg_wr && reg_addr == A_SET) mask_q <= mask_q | reg_wdata[NB-1:0];
      if (reg_wr && reg_addr == A_CLR) mask_q <= mask_q & ~reg_wdata[NB-1:0];
      if (reg_wr && reg_addr == A_TTHR) tx_thr_q <= reg_wdata;
      if (reg_wr && reg_addr == A_RTHR) rx_thr_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_STAT:  reg_rdata = DATA_W'(status);
        A_MASK:  reg_rdata = DATA_W'(mask_q);
        A_TTHR:  reg_rdata = tx_thr_q;
        A_RTHR:  reg_rdata = rx_thr_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  AST_UNDERFLOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_underflow |=> sticky_q[6]); // R10
  AST_OVERFLOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overflow |=> sticky_q[0]); // R2
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[1] && !reg_wr && !reg_rd) |=> sticky_q[1]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STAT && !ev_tx_underflow && !ev_rx_overflow && !ev_mode_fault)
    |=> (sticky_q == '0)); // R7
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[0] && !ev_rx_overflow) |=> !sticky_q[0]); // R6
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SET)
    |=> ((mask_q & $past(reg_wdata[NB-1:0])) == $past(reg_wdata[NB-1:0]))); // R5
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR) |=> ((mask_q & $past(reg_wdata[NB-1:0])) == '0)); // R5
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == A_SET || reg_addr == A_CLR)) |=> $stable(mask_q)); // R5
  AST_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8

endmodule

// File: tb/sim_spi_irq_aggr.sv
module sim_spi_irq_aggr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] tx_level = '0, rx_level = '0;
  logic       tx_full = 1'b0, rx_full = 1'b0;
  logic       ev_tx_underflow = 1'b0, ev_rx_overflow = 1'b0, ev_mode_fault = 1'b0;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [6:0] m_sticky = '0, m_mask = '0;
  logic [7:0] m_tthr = 8'd1, m_rthr = 8'd1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_aggr u0 (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level), .rx_level(rx_level),
    .tx_full(tx_full), .rx_full(rx_full), .ev_tx_underflow(ev_tx_underflow),
    .ev_rx_overflow(ev_rx_overflow), .ev_mode_fault(ev_mode_fault), .irq(irq)
  );

  function automatic logic [6:0] exp_status();
    return m_sticky | {1'b0, rx_full, ({2'b00, rx_level} >= m_rthr), tx_full,
                       ({2'b00, tx_level} < m_tthr), 2'b00};
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, exp_status()};
      3'd3: return {1'b0, m_mask};
      3'd4: return m_tthr;
      3'd5: return m_rthr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1 R7 status read";
      3'd3: return "R5 mask read";
      3'd4, 3'd5: return "R4 threshold read";
      default: return "R11 zero read";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d,
                     input logic [2:0] ev, input logic [5:0] txc, input logic [5:0] rxc,
                     input bit txf, input bit rxf, input string tag);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    ev_rx_overflow = ev[0]; ev_mode_fault = ev[1]; ev_tx_underflow = ev[2];
    tx_level = txc; rx_level = rxc; tx_full = txf; rx_full = rxf;
    #1;
    check({tag, " R8 irq"}, {7'd0, irq}, {7'd0, |(m_mask & exp_status())});
    if (rd) check(tag, reg_rdata, exp_read(a));
    @(posedge clk);
    if (wr) begin
      case (a)
        3'd0: m_sticky = m_sticky & ~d[6:0];
        3'd1: m_mask = m_mask | d[6:0];
        3'd2: m_mask = m_mask & ~d[6:0];
        3'd4: m_tthr = d;
        3'd5: m_rthr = d;
        default: ;
      endcase
    end
    if (rd && a == 3'd0) m_sticky = '0;
    m_sticky = m_sticky | {ev[2], 4'b0000, ev[1], ev[0]};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state
    cyc(1, 0, 3'd4, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R9 tx threshold reset");
    cyc(1, 0, 3'd5, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R9 rx threshold reset");
    cyc(1, 0, 3'd3, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R9 mask reset");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R9 status reset");

    // R2 capture and hold, R1 layout
    cyc(0, 0, 3'd0, 8'h00, 3'b111, 6'd0, 6'd0, 0, 0, "R2 events");
    cyc(0, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R2 hold");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R1 R2 sticky read");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R7 cleared after read");

    // R3 live full flags
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd4, 6'd9, 1, 1, "R3 full flags high");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd4, 6'd9, 0, 0, "R3 full flags low");

    // R4 threshold boundaries
    cyc(0, 1, 3'd5, 8'd5, 3'b000, 6'd0, 6'd0, 0, 0, "R4 set rx threshold");
    cyc(0, 1, 3'd4, 8'd3, 3'b000, 6'd0, 6'd0, 0, 0, "R4 set tx threshold");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd2, 6'd4, 0, 0, "R4 below boundaries");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd3, 6'd5, 0, 0, "R4 at boundaries");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd4, 6'd6, 0, 0, "R4 above boundaries");

    // R5 mask set/clear, mask address write ignored
    cyc(0, 1, 3'd1, 8'h55, 3'b000, 6'd0, 6'd0, 0, 0, "R5 enable write");
    cyc(0, 1, 3'd2, 8'h14, 3'b000, 6'd0, 6'd0, 0, 0, "R5 disable write");
    cyc(0, 1, 3'd3, 8'h7f, 3'b000, 6'd0, 6'd0, 0, 0, "R5 mask write ignored");
    cyc(1, 0, 3'd3, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R5 mask readback");

    // R11 zero reads
    cyc(1, 0, 3'd1, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R11 enable reads zero");
    cyc(1, 0, 3'd2, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R11 disable reads zero");
    cyc(1, 0, 3'd7, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R11 unused reads zero");

    // R6 write-one-to-clear, partial
    cyc(0, 0, 3'd0, 8'h00, 3'b111, 6'd0, 6'd0, 0, 0, "R6 set all sticky");
    cyc(0, 1, 3'd0, 8'h41, 3'b000, 6'd0, 6'd0, 0, 0, "R6 clear bits 0 and 6");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R6 only mode fault left");

    // R10 event wins over clears
    cyc(1, 0, 3'd0, 8'h00, 3'b100, 6'd0, 6'd0, 0, 0, "R10 read with underflow");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R10 underflow survived read");
    cyc(0, 1, 3'd0, 8'h01, 3'b001, 6'd0, 6'd0, 0, 0, "R10 w1c with overflow");
    cyc(1, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R10 overflow survived w1c");

    // R8 irq with full mask
    cyc(0, 1, 3'd1, 8'h7f, 3'b000, 6'd0, 6'd0, 0, 0, "R8 enable all");
    cyc(0, 0, 3'd0, 8'h00, 3'b000, 6'd0, 6'd0, 0, 0, "R8 irq on tx below threshold");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 3);
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      logic [2:0] ev = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      if (op == 2 && (a == 3'd4 || a == 3'd5)) d = 8'($urandom_range(0, 40));
      cyc(op == 1, op == 2, a, d, ev, 6'($urandom_range(0, 32)), 6'($urandom_range(0, 32)),
          1'($urandom), 1'($urandom), op == 1 ? tag_of(a) : "R2 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule